// File: doc/BRIEF.md
# Wall-Following Robot Steering Controller

This block is the steering brain of a small robot that finds its way through a maze by keeping a wall on its right-hand side. Two contact sensors, one on each antenna, feed it. On every clock it picks one of four behaviours and drives three motion strobes: step forward, veer left and veer right. The motor side carries out the strobes.

The controller is a Moore machine with four states. A wander state walks forward until the robot bumps into anything. A pivot state turns left on the spot while something is still in contact. A hug state edges left while it moves along a wall it is touching. A seek state edges right while it moves, to find the wall again after losing contact. The strobes are decoded only from the registered state, so a sensor change reaches the motors one clock later. The state code is also driven out so that the surrounding logic can see it.

Top module: `wf_walker`

## Requirements
- R1: While the synchronous, active-high `rst` is sampled high at a rising edge, the machine enters wander mode. In that mode `modeCode` is 2'b00 and the only strobe asserted is `stepFwd`. This also holds when reset is applied from any other mode.
- R2: A sensor input reads 1 while its antenna touches a wall and 0 otherwise. Both inputs at 1 means the way ahead is blocked.
- R3: In wander mode, an edge with both sensors at 0 keeps wander mode. An edge with either sensor at 1 moves to pivot mode.
- R4: Pivot mode has code 2'b01 and asserts only `veerLeft`. An edge with both sensors at 0 moves to seek mode. Any other input keeps pivot mode.
- R5: Hug mode has code 2'b10 and asserts `veerLeft` and `stepFwd`. With left=0 and right=0 it moves to seek mode. With left=0 and right=1 it stays in hug mode. With left=1 it moves to pivot mode, whatever the right sensor reads.
- R6: Seek mode has code 2'b11 and asserts `veerRight` and `stepFwd`. With left=0 and right=0 it stays in seek mode. With left=0 and right=1 it moves to hug mode. With left=1 it moves to pivot mode.
- R7: The strobes and `modeCode` depend only on the registered state. A change on the sensors between clock edges leaves them unchanged until the next rising edge.
- R8: `veerLeft` and `veerRight` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset to wander mode |
| leftTouch | input | 1 | Left antenna contact, 1 while touching |
| rightTouch | input | 1 | Right antenna contact, 1 while touching |
| stepFwd | output | 1 | Move forward one step |
| veerLeft | output | 1 | Turn slightly left |
| veerRight | output | 1 | Turn slightly right |
| modeCode | output | 2 | Current mode: 00 wander, 01 pivot, 10 hug, 11 seek |

## Verification
The bench drives each mode through every sensor combination, including the don't-care right sensor when the left sensor is touching in hug and seek modes. A design that ignored that don't-care would stall against a wall or slide along it, instead of pivoting. It also changes the sensors in the middle of a cycle and checks that the strobes hold until the edge; a design with a combinational path from the sensors would fail that check. Reset is applied from hug mode to confirm that it is synchronous and takes effect from any state. Leaving pivot mode only when both sensors clear catches a machine that jumps to seek mode while the wall ahead is still touching.

// File: rtl/wf_walker_pkg.sv
package wf_walker_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_WANDER = 2'b00,
    MODE_PIVOT  = 2'b01,
    MODE_HUG    = 2'b10,
    MODE_SEEK   = 2'b11
  } modeE;

  typedef struct packed {
    logic fwd;
    logic left;
    logic right;
  } moveS;
endpackage

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_walker_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic leftTouch,
  input  logic rightTouch,
  output modeE modeQ
);
  modeE modeD;

  always_comb begin
    modeD = modeQ;
    unique case (modeQ)
      MODE_WANDER: modeD = (leftTouch || rightTouch) ? MODE_PIVOT : MODE_WANDER;
      MODE_PIVOT:  modeD = (leftTouch || rightTouch) ? MODE_PIVOT : MODE_SEEK;
      MODE_HUG: begin
        if (leftTouch)       modeD = MODE_PIVOT;
        else if (rightTouch) modeD = MODE_HUG;
        else                 modeD = MODE_SEEK;
      end
      MODE_SEEK: begin
        if (leftTouch)       modeD = MODE_PIVOT;
        else if (rightTouch) modeD = MODE_HUG;
        else                 modeD = MODE_SEEK;
      end
      default: modeD = MODE_WANDER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) modeQ <= MODE_WANDER;
    else     modeQ <= modeD;
  end
endmodule

// File: rtl/wf_decode.sv
module wf_decode
  import wf_walker_pkg::*;
(
  input  modeE modeQ,
  output moveS moves
);
  always_comb begin
    moves = '0;
    unique case (modeQ)
      MODE_WANDER: moves.fwd = 1'b1;
      MODE_PIVOT:  moves.left = 1'b1;
      MODE_HUG:    begin moves.left = 1'b1;  moves.fwd = 1'b1; end
      MODE_SEEK:   begin moves.right = 1'b1; moves.fwd = 1'b1; end
      default:     moves = '0;
    endcase
  end
endmodule

// File: rtl/wf_walker.sv
module wf_walker
  import wf_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              leftTouch,
  input  logic              rightTouch,
  output logic              stepFwd,
  output logic              veerLeft,
  output logic              veerRight,
  output logic [MODE_W-1:0] modeCode
);
  modeE modeQ;
  moveS moves;

  wf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .leftTouch(leftTouch), .rightTouch(rightTouch), .modeQ(modeQ)
  );

  wf_decode u_decode (.modeQ(modeQ), .moves(moves));

  assign stepFwd   = moves.fwd;
  assign veerLeft  = moves.left;
  assign veerRight = moves.right;
  assign modeCode  = modeQ;
endmodule

// File: rtl/wf_walker_chk.sv
module wf_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       leftTouch,
  input logic       rightTouch,
  input logic       stepFwd,
  input logic       veerLeft,
  input logic       veerRight,
  input logic [1:0] modeCode
);
  logic rstD;
  always_ff @(posedge clk) rstD <= rst;

  p_reset_wander_r1: assert property (@(posedge clk) disable iff (rst)
    rstD |-> (modeCode == 2'b00 && stepFwd && !veerLeft && !veerRight));

  p_wander_stay_r3: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b00 && !leftTouch && !rightTouch) |=> modeCode == 2'b00);
  p_wander_bump_r3: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b00 && (leftTouch || rightTouch)) |=> modeCode == 2'b01);

  p_pivot_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b01 && (leftTouch || rightTouch)) |=> modeCode == 2'b01);
  p_pivot_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b01 && !leftTouch && !rightTouch) |=> modeCode == 2'b11);
  p_pivot_out_r4: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b01 |-> (veerLeft && !stepFwd && !veerRight));

  p_hug_left_r5: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b10 && leftTouch) |=> modeCode == 2'b01);
  p_hug_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b10 && !leftTouch && rightTouch) |=> modeCode == 2'b10);
  p_hug_lost_r5: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b10 && !leftTouch && !rightTouch) |=> modeCode == 2'b11);
  p_hug_out_r5: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b10 |-> (veerLeft && stepFwd && !veerRight));

  p_seek_left_r6: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b11 && leftTouch) |=> modeCode == 2'b01);
  p_seek_find_r6: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b11 && !leftTouch && rightTouch) |=> modeCode == 2'b10);
  p_seek_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (modeCode == 2'b11 && !leftTouch && !rightTouch) |=> modeCode == 2'b11);
  p_seek_out_r6: assert property (@(posedge clk) disable iff (rst)
    modeCode == 2'b11 |-> (veerRight && stepFwd && !veerLeft));

  p_no_dual_turn_r8: assert property (@(posedge clk) disable iff (rst)
    !(veerLeft && veerRight));
endmodule

bind wf_walker wf_walker_chk u_chk (
  .clk(clk), .rst(rst), .leftTouch(leftTouch), .rightTouch(rightTouch),
  .stepFwd(stepFwd), .veerLeft(veerLeft), .veerRight(veerRight), .modeCode(modeCode)
);

// File: tb/wf_walker_bench.sv
module wf_walker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic leftTouch = 1'b0;
  logic rightTouch = 1'b0;
  logic stepFwd, veerLeft, veerRight;
  logic [1:0] modeCode;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wf_walker u_wf_walker (
    .clk(clk), .rst(rst), .leftTouch(leftTouch), .rightTouch(rightTouch),
    .stepFwd(stepFwd), .veerLeft(veerLeft), .veerRight(veerRight), .modeCode(modeCode)
  );

  task automatic expect_mode(input string tag, input logic [1:0] m);
    logic [2:0] want;
    case (m)
      2'b00: want = 3'b100;
      2'b01: want = 3'b010;
      2'b10: want = 3'b110;
      default: want = 3'b101;
    endcase
    checks++;
    if (modeCode !== m || {stepFwd, veerLeft, veerRight} !== want) begin
      errors++;
      $display("FAIL %s: mode=%b outs(fwd,left,right)=%b expected mode=%b outs=%b",
               tag, modeCode, {stepFwd, veerLeft, veerRight}, m, want);
    end
    checks++;
    if (veerLeft === 1'b1 && veerRight === 1'b1) begin
      errors++;
      $display("FAIL R8: left=%b right=%b expected not both high", veerLeft, veerRight);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic l, input logic r);
    @(negedge clk);
    leftTouch = l; rightTouch = r;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; leftTouch = 1'b0; rightTouch = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic go_hug();
    do_reset();
    step(1'b0, 1'b1); step(1'b0, 1'b0); step(1'b0, 1'b1);
    expect_mode("R6 setup reach hug", 2'b10);
  endtask

  task automatic t_reset();
    do_reset();
    expect_mode("R1 reset state", 2'b00);
  endtask

  task automatic t_wander();
    do_reset();
    step(1'b0, 1'b0); expect_mode("R3 wander stays on no contact", 2'b00);
    step(1'b0, 1'b1); expect_mode("R2 R3 wander to pivot on right", 2'b01);
    do_reset(); step(1'b1, 1'b0); expect_mode("R3 wander to pivot on left", 2'b01);
    do_reset(); step(1'b1, 1'b1); expect_mode("R3 wander to pivot on front", 2'b01);
  endtask

  task automatic t_pivot();
    do_reset(); step(1'b1, 1'b1);
    step(1'b1, 1'b1); expect_mode("R4 pivot holds front", 2'b01);
    step(1'b1, 1'b0); expect_mode("R4 pivot holds left", 2'b01);
    step(1'b0, 1'b1); expect_mode("R4 pivot holds right", 2'b01);
    step(1'b0, 1'b0); expect_mode("R4 pivot to seek", 2'b11);
  endtask

  task automatic t_seek();
    do_reset(); step(1'b1, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b0); expect_mode("R6 seek stays", 2'b11);
    step(1'b0, 1'b1); expect_mode("R6 seek to hug", 2'b10);
    step(1'b0, 1'b0); step(1'b1, 1'b0); expect_mode("R6 seek to pivot left only", 2'b01);
    step(1'b0, 1'b0); step(1'b1, 1'b1); expect_mode("R6 seek to pivot front", 2'b01);
  endtask

  task automatic t_hug();
    go_hug();
    step(1'b0, 1'b1); expect_mode("R5 hug stays", 2'b10);
    step(1'b0, 1'b0); expect_mode("R5 hug to seek", 2'b11);
    go_hug(); step(1'b1, 1'b0); expect_mode("R5 hug to pivot left only", 2'b01);
    go_hug(); step(1'b1, 1'b1); expect_mode("R5 hug to pivot front", 2'b01);
  endtask

  task automatic t_moore();
    do_reset();
    @(negedge clk); leftTouch = 1'b1; #3;
    expect_mode("R7 no change before edge", 2'b00);
    leftTouch = 1'b0; rightTouch = 1'b1; #3;
    expect_mode("R7 still no change mid cycle", 2'b00);
    @(posedge clk); #1;
    expect_mode("R7 change after edge", 2'b01);
  endtask

  task automatic t_reset_mid();
    go_hug();
    @(negedge clk); rst = 1'b1; leftTouch = 1'b0; rightTouch = 1'b1; #3;
    expect_mode("R1 reset is synchronous", 2'b10);
    @(posedge clk); #1;
    expect_mode("R1 reset from hug", 2'b00);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_wander();
    t_pivot();
    t_seek();
    t_hug();
    t_moore();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule